// File: doc/BRIEF.md
# Multi-channel down-counting event timer

This block is a bank of independent event timers, two or four of them as chosen by a parameter, behind a 32-bit memory-mapped register port. Each channel holds a 64-bit interval and a 64-bit down-counter. Both are split into low and high 32-bit words. The counter is clocked from the bus clock through a per-channel power-of-two prescaler. When the counter runs out, the channel raises its status bit. It then either reloads the interval and keeps running (periodic) or halts (one-shot).

Software sets up a channel in three steps: it writes the interval words, pulses the reload bit to preset the counter, and sets the enable bit. One shared enable register and one shared status register hold a bit per channel. Each channel drives its own interrupt line.

A disable does not stop a channel at once. The channel keeps counting for a fixed two further clock cycles, so software sees a deterministic stop point. The counter can be read without tearing: a read of the low count word captures the high word for a later read.

Top module: `evt_tmr_bank`

## Requirements
- R1: After reset every register reads zero and every interrupt line is low.
- R2: The register map is as follows. Interrupt enable is at 0x00 and interrupt status is at 0x04, with bit n belonging to channel n. Channel n starts at base 0x10 + 0x20*n. From that base, control is at +0x00, the interval low and high words are at +0x04 and +0x08, and the count low and high words are at +0x0C and +0x10. Read data is valid in the cycle after the read strobe. Accesses to one channel leave the others unchanged.
- R3: The control register fields are: bit 0 enable, bit 1 reload, bits 6:4 prescaler select, bit 7 one-shot (0 selects periodic). The reload bit always reads back as 0.
- R4: Writing control with bit 1 set loads the counter from the interval at the clock edge of that write.
- R5: Any load of the counter, by the reload bit or by a periodic expiry, uses the interval raised to at least 3.
- R6: While a channel is active, a count tick occurs once every 2^sel clock cycles. The first tick falls on the 2^sel-th edge after the channel becomes active.
- R7: Each tick decrements a nonzero count. A tick that finds the count at zero is an expiry, and the expiry sets the channel's status bit.
- R8: In periodic mode an expiry reloads the counter, which gives one expiry every (loaded value + 1) ticks.
- R9: In one-shot mode an expiry clears the enable bit. The count stays at zero.
- R10: When a bus write clears the enable bit, the channel stays active for two more clock cycles and then halts.
- R11: Writing 1 to a status bit clears it. If an expiry falls in the same cycle, the set wins.
- R12: Interrupt line n is high exactly while status bit n and enable bit n are both set. Masking does not clear the status bit.
- R13: A read of the count high word returns the value captured by the most recent read of that channel's count low word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, also the timer source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | NCH | One interrupt line per channel |

## Verification
An expiry can set a status bit in the same cycle that a bus write tries to clear it. The bench provokes this on a periodic channel: it counts the period exactly and lands the write-one-to-clear on the expiry edge. The interrupt line must then still be high in the following cycle, whereas a clear on any other edge drops it. The same cycle accounting settles the stop window. A disable written one cycle after enable must leave the counter exactly three ticks lower. With a prescaler of four, a 15-cycle run followed by a disable must give exactly four ticks.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

    localparam int REG_W     = 32;
    localparam int CNT_W     = 2 * REG_W;
    localparam int PS_W      = 3;
    localparam int STOP_LAT  = 2;

    // control bit positions (decoded by software)
    localparam int CTL_EN    = 0;
    localparam int CTL_LD    = 1;
    localparam int CTL_PS_LO = 4;
    localparam int CTL_OS    = 7;

    // shared and per-channel offsets
    localparam int OFF_IE    = 'h00;
    localparam int OFF_ST    = 'h04;
    localparam int CH_BASE   = 'h10;
    localparam int CH_STRIDE = 'h20;
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_ILO   = 'h04;
    localparam int OFF_IHI   = 'h08;
    localparam int OFF_CLO   = 'h0C;
    localparam int OFF_CHI   = 'h10;

    localparam logic [CNT_W-1:0] MIN_LOAD = CNT_W'(3);

    typedef struct packed {
        logic            oneshot;
        logic [PS_W-1:0] psel;
        logic            en;
    } ch_cfg_t;

    function automatic int reg_addr(int ch, int off);
        return CH_BASE + CH_STRIDE * ch + off;
    endfunction

    function automatic logic [CNT_W-1:0] clamp_load(logic [CNT_W-1:0] v);
        return (v < MIN_LOAD) ? MIN_LOAD : v;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(ch_cfg_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[CTL_EN] = c.en;
        r[CTL_PS_LO +: PS_W] = c.psel;
        r[CTL_OS] = c.oneshot;
        return r;
    endfunction

endpackage

// File: rtl/evt_tmr_presc.sv
module evt_tmr_presc #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   one_hot;
    logic [PRE_W-1:0] mask;

    always_comb begin
        one_hot = (PRE_W + 1)'(1) << sel;
        mask    = PRE_W'(one_hot - 1'b1);
        tick    = active && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !active) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/evt_tmr_chan.sv
module evt_tmr_chan
    import evt_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_ilo,
    input  logic             wr_ihi,
    input  logic [REG_W-1:0] wdata,
    input  logic             tick,
    output ch_cfg_t          cfg,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ivl,
    output logic             active,
    output logic             expire
);
    localparam int SC_W = $clog2(STOP_LAT + 1);

    logic [SC_W-1:0] stop_q;
    logic            load;

    always_comb begin
        load   = wr_ctrl && wdata[CTL_LD];
        expire = tick && (cnt == '0);
        active = cfg.en || (stop_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            cnt    <= '0;
            ivl    <= '0;
            stop_q <= '0;
        end else begin
            if (wr_ilo) ivl[REG_W-1:0]     <= wdata;
            if (wr_ihi) ivl[CNT_W-1:REG_W] <= wdata;

            if (wr_ctrl) begin
                cfg.en      <= wdata[CTL_EN];
                cfg.psel    <= wdata[CTL_PS_LO +: PS_W];
                cfg.oneshot <= wdata[CTL_OS];
                if (wdata[CTL_EN])                    stop_q <= '0;
                else if (cfg.en)                      stop_q <= SC_W'(STOP_LAT);
                else if (stop_q != '0)                stop_q <= stop_q - 1'b1;
            end else begin
                if (expire && cfg.oneshot) cfg.en <= 1'b0;
                if (stop_q != '0)          stop_q <= stop_q - 1'b1;
            end

            if (load)        cnt <= clamp_load(ivl);
            else if (expire) cnt <= cfg.oneshot ? '0 : clamp_load(ivl);
            else if (tick)   cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/evt_tmr_bank.sv
module evt_tmr_bank
    import evt_tmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [NCH-1:0]    irq
);
    logic [NCH-1:0]             ie_q, stat_q;
    logic [NCH-1:0]             wr_ctrl, wr_ilo, wr_ihi;
    logic [NCH-1:0]             tick_v, active_v, expire_v, en_v, os_v;
    logic [NCH-1:0][CNT_W-1:0]  cnt_v, ivl_v;
    logic [NCH-1:0][REG_W-1:0]  shadow_q;
    ch_cfg_t                    cfg_v [NCH];
    logic                       wr_ie, wr_st;
    logic [REG_W-1:0]           rd_mux;

    always_comb begin
        wr_ie = wr_en && (addr == ADDR_W'(OFF_IE));
        wr_st = wr_en && (addr == ADDR_W'(OFF_ST));
        for (int n = 0; n < NCH; n++) begin
            wr_ctrl[n] = wr_en && (addr == ADDR_W'(reg_addr(n, OFF_CTRL)));
            wr_ilo[n]  = wr_en && (addr == ADDR_W'(reg_addr(n, OFF_ILO)));
            wr_ihi[n]  = wr_en && (addr == ADDR_W'(reg_addr(n, OFF_IHI)));
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        evt_tmr_presc #(.SEL_W(PS_W)) u_presc (
            .clk    (clk),
            .rst    (rst),
            .active (active_v[g]),
            .sel    (cfg_v[g].psel),
            .tick   (tick_v[g])
        );
        evt_tmr_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_ctrl (wr_ctrl[g]),
            .wr_ilo  (wr_ilo[g]),
            .wr_ihi  (wr_ihi[g]),
            .wdata   (wdata),
            .tick    (tick_v[g]),
            .cfg     (cfg_v[g]),
            .cnt     (cnt_v[g]),
            .ivl     (ivl_v[g]),
            .active  (active_v[g]),
            .expire  (expire_v[g])
        );
        assign en_v[g] = cfg_v[g].en;
        assign os_v[g] = cfg_v[g].oneshot;
    end

    // shared enable and status; an expiry outranks a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= '0;
            stat_q <= '0;
        end else begin
            if (wr_ie) ie_q <= wdata[NCH-1:0];
            stat_q <= (stat_q & ~(wr_st ? wdata[NCH-1:0] : '0)) | expire_v;
        end
    end

    assign irq = stat_q & ie_q;

    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(OFF_IE)) rd_mux[NCH-1:0] = ie_q;
        if (addr == ADDR_W'(OFF_ST)) rd_mux[NCH-1:0] = stat_q;
        for (int n = 0; n < NCH; n++) begin
            if (addr == ADDR_W'(reg_addr(n, OFF_CTRL))) rd_mux = pack_ctrl(cfg_v[n]);
            if (addr == ADDR_W'(reg_addr(n, OFF_ILO)))  rd_mux = ivl_v[n][REG_W-1:0];
            if (addr == ADDR_W'(reg_addr(n, OFF_IHI)))  rd_mux = ivl_v[n][CNT_W-1:REG_W];
            if (addr == ADDR_W'(reg_addr(n, OFF_CLO)))  rd_mux = cnt_v[n][REG_W-1:0];
            if (addr == ADDR_W'(reg_addr(n, OFF_CHI)))  rd_mux = shadow_q[n];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            shadow_q <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
            for (int n = 0; n < NCH; n++)
                if (addr == ADDR_W'(reg_addr(n, OFF_CLO)))
                    shadow_q[n] <= cnt_v[n][CNT_W-1:REG_W];
        end
    end
endmodule

// File: rtl/evt_tmr_chk.sv
module evt_tmr_chk
    import evt_tmr_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wd_en,
    input logic                     wd_ld,
    input logic [NCH-1:0]           wr_ctrl,
    input logic [NCH-1:0]           tick_v,
    input logic [NCH-1:0]           en_v,
    input logic [NCH-1:0]           os_v,
    input logic [NCH-1:0]           active_v,
    input logic [NCH-1:0]           stat_q,
    input logic [NCH-1:0]           irq,
    input logic [NCH-1:0][CNT_W-1:0] cnt_v,
    input logic [NCH-1:0][CNT_W-1:0] ivl_v
);
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        rst |=> (irq == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R4 and R5: a reload write presets the counter
        p_reload_load_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_ctrl[i] && wd_ld) |=> (cnt_v[i] == clamp_load($past(ivl_v[i]))));

        p_tick_decrement_r7: assert property (@(posedge clk) disable iff (rst)
            (tick_v[i] && cnt_v[i] != '0 && !(wr_ctrl[i] && wd_ld))
            |=> (cnt_v[i] == $past(cnt_v[i]) - 1'b1));

        p_expiry_wins_r11: assert property (@(posedge clk) disable iff (rst)
            (tick_v[i] && cnt_v[i] == '0) |=> stat_q[i]);

        p_periodic_reload_r8: assert property (@(posedge clk) disable iff (rst)
            (tick_v[i] && cnt_v[i] == '0 && !os_v[i] && !(wr_ctrl[i] && wd_ld))
            |=> (cnt_v[i] == clamp_load($past(ivl_v[i]))));

        p_oneshot_halt_r9: assert property (@(posedge clk) disable iff (rst)
            (tick_v[i] && cnt_v[i] == '0 && os_v[i] && !wr_ctrl[i])
            |=> (!en_v[i] && cnt_v[i] == '0));

        p_stop_window_r10: assert property (@(posedge clk) disable iff (rst)
            (wr_ctrl[i] && !wd_en && en_v[i]) |=> active_v[i] ##1 active_v[i]);
    end
endmodule

bind evt_tmr_bank evt_tmr_chk #(.NCH(NCH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wd_en    (wdata[0]),
    .wd_ld    (wdata[1]),
    .wr_ctrl  (wr_ctrl),
    .tick_v   (tick_v),
    .en_v     (en_v),
    .os_v     (os_v),
    .active_v (active_v),
    .stat_q   (stat_q),
    .irq      (irq),
    .cnt_v    (cnt_v),
    .ivl_v    (ivl_v)
);

// File: tb/evt_tmr_bank_tb_top.sv
module evt_tmr_bank_tb_top;
    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [7:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NCH-1:0]    irq;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_seen = 1'b0;

    always #10 clk = ~clk;

    evt_tmr_bank #(.NCH(NCH)) dut_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each returned read against the scoreboard
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        exp_t e;
        if (rd_seen) begin
            if (exp_q.size() == 0) check(rdata, 32'hDEAD_BEEF, "R2 unexpected read");
            else begin
                e = exp_q.pop_front();
                check(rdata, e.val, e.tag);
            end
        end
    end

    // tasks start and end right after a falling edge
    task automatic bus_wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = 8'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.val = exp; e.tag = tag;
        exp_q.push_back(e);
        rd_en = 1'b1; addr = 8'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        check(32'd0, 32'd1, "R1 watchdog");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;

        // R1 reset state
        check(32'(irq), 32'd0, "R1 irq after reset");
        bus_rd('h00, 0, "R1 ie");
        bus_rd('h04, 0, "R1 status");
        bus_rd('h10, 0, "R1 ctrl");
        bus_rd('h1C, 0, "R1 count lo");
        bus_rd('h20, 0, "R1 count hi");

        // R4 reload, R13 snapshot, R3 reload reads 0
        bus_wr('h14, 32'h10);
        bus_wr('h18, 32'h1);
        bus_wr('h10, 32'h2);
        bus_rd('h1C, 32'h10, "R4 count lo after reload");
        bus_rd('h20, 32'h1,  "R13 hi after lo read");
        bus_rd('h10, 32'h0,  "R3 reload bit reads 0");
        bus_wr('h14, 32'h20);
        bus_wr('h18, 32'h2);
        bus_wr('h10, 32'h2);
        bus_rd('h20, 32'h1,  "R13 hi is stale snapshot");
        bus_rd('h1C, 32'h20, "R4 count lo second reload");
        bus_rd('h20, 32'h2,  "R13 hi refreshed");

        // R3 field positions
        bus_wr('h10, 32'hF0);
        bus_rd('h10, 32'hF0, "R3 ctrl fields");
        bus_wr('h10, 32'h0);

        // R5 minimum load
        bus_wr('h14, 32'h1);
        bus_wr('h18, 32'h0);
        bus_wr('h10, 32'h2);
        bus_rd('h1C, 32'd3, "R5 clamped load");

        // R6 prescale by 4: 15 enabled cycles plus 2 stop cycles -> 4 ticks
        bus_wr('h14, 32'd100);
        bus_wr('h10, 32'h2);
        bus_wr('h10, 32'h21);
        idle(14);
        bus_wr('h10, 32'h20);
        idle(4);
        bus_rd('h1C, 32'd96, "R6 prescaled ticks");

        // R10 stop window with no prescale
        bus_wr('h14, 32'd50);
        bus_wr('h10, 32'h2);
        bus_wr('h10, 32'h1);
        bus_wr('h10, 32'h0);
        idle(4);
        bus_rd('h1C, 32'd47, "R10 two extra cycles after disable");

        // R7 R8 R11 R12 periodic expiry, period 5
        bus_wr('h00, 32'h1);
        bus_wr('h14, 32'd4);
        bus_wr('h10, 32'h3);
        idle(4);
        check(32'(irq[0]), 0, "R7 no irq before expiry");
        idle(1);
        check(32'(irq[0]), 1, "R7 irq at expiry");
        bus_wr('h04, 32'h1);
        check(32'(irq[0]), 0, "R11 clear drops irq");
        idle(3);
        check(32'(irq[0]), 0, "R8 not yet second expiry");
        idle(1);
        check(32'(irq[0]), 1, "R8 periodic second expiry");
        idle(4);
        bus_wr('h04, 32'h1);
        check(32'(irq[0]), 1, "R11 set wins over clear");
        bus_wr('h10, 32'h0);
        bus_wr('h00, 32'h0);
        check(32'(irq[0]), 0, "R12 masked irq low");
        bus_rd('h04, 32'h1, "R12 status kept while masked");
        bus_wr('h04, 32'h1);
        bus_rd('h04, 32'h0, "R11 status cleared");

        // R9 one-shot
        bus_wr('h00, 32'h1);
        bus_wr('h14, 32'd3);
        bus_wr('h10, 32'h83);
        idle(3);
        check(32'(irq[0]), 0, "R9 before one-shot expiry");
        idle(1);
        check(32'(irq[0]), 1, "R9 one-shot expiry");
        idle(10);
        bus_rd('h10, 32'h80, "R9 enable cleared");
        bus_rd('h1C, 32'h0,  "R9 count held at zero");
        bus_rd('h04, 32'h1,  "R9 status set");

        // R2 last channel map and isolation
        bus_wr('h74, 32'h1234);
        bus_wr('h78, 32'hAB);
        bus_wr('h70, 32'h2);
        bus_rd('h7C, 32'h1234, "R2 channel 3 count lo");
        bus_rd('h80, 32'hAB,   "R2 channel 3 count hi");
        bus_rd('h1C, 32'h0,    "R2 channel 0 untouched");
        check(32'(irq[NCH-1:1]), 0, "R2 other irq lines low");

        idle(2);
        check(32'(exp_q.size()), 0, "R2 all reads returned");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule